// File: doc/BRIEF.md
# Hysteresis Edge Thresholding Window

This block takes a raster stream of gradient magnitudes after non-maximum suppression and gives a binary edge label for each interior pixel. Each magnitude comes with a direction bit that is set when the pixel's edge direction lies in the band from π/4 to 3π/4. Two line delays of one image row each, plus two columns of pipeline registers, form a 3×3 neighbourhood around the centre pixel. The centre is then labelled with a pair of thresholds. The high threshold comes from an adaptive thresholding unit outside this block. The low threshold is the high threshold shifted right by one bit.

The adaptive unit computes its value from one frame's histogram and loads it through a one-cycle load port. The block holds the loaded value as pending and switches to it at the next start-of-frame pixel. Every frame is therefore labelled with a threshold taken from an earlier frame, and the stream never waits for a threshold computation. The input stream may pause at any point by dropping `in_valid`.

Top module: `hyst_edge_thresh`

## Requirements
- R1: An accepted input pixel at row r and column c, with r ≥ 1 and c ≥ 1, produces `out_valid` = 1 one clock later. `out_edge` then labels the centre position (r−1, c−1). Every other cycle has `out_valid` = 0 and `out_edge` = 0, and this includes the cycles in reset.
- R2: An interior centre with `in_inband` = 1 and a magnitude strictly greater than the active high threshold is an edge.
- R3: A centre whose magnitude is strictly less than the low threshold (high >> 1) is not an edge.
- R4: A centre whose magnitude lies between the low and high thresholds, with both ends included, is an edge only if at least one of its 8 neighbours is strictly greater than the high threshold.
- R5: A centre whose direction bit `in_inband` is 0 (outside π/4..3π/4) is never an edge, whatever its magnitude.
- R6: A centre on row 0 or column 0 of a frame is never an edge.
- R7: `thr_load` = 1 stores `thr_value` as pending. The active high threshold changes only on an accepted start-of-frame pixel, and it then takes the pending value. If the load arrives in the same cycle as that pixel, the new `thr_value` is taken directly. After reset the active and pending thresholds both equal `INIT_HI`.
- R8: Cycles with `in_valid` = 0 do not move the window or the position, and the labels that follow are the same as for an unbroken stream.
- R9: An accepted pixel with `in_sof` = 1 is at row 0, column 0, even when the previous frame ended partway through a row. Positions then advance in raster order over `IMG_W` columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel accepted this cycle |
| in_sof | input | 1 | Accepted pixel is the first of a frame |
| in_mag | input | MAG_W | Suppressed gradient magnitude |
| in_inband | input | 1 | 1 when the edge direction is within π/4..3π/4 |
| thr_load | input | 1 | Load strobe for the next frame's high threshold |
| thr_value | input | MAG_W | High threshold value to load |
| out_valid | output | 1 | A centre label is present |
| out_edge | output | 1 | 1 when the labelled centre is an edge |

## Verification
The hardest case to reach from the ports is the linked case. It needs a centre that sits exactly on one of the two threshold bounds, or between them, while a strong pixel lies in one particular one of its 8 neighbour slots. A second hard case is a threshold load that lands in the middle of a frame or in the same cycle as start-of-frame. A directed frame places pixels at the exact bounds and at the bounds ±1, next to and away from a strong pixel. Random frames draw magnitudes from a set clustered around the active thresholds. Loads are issued in the middle of a frame, together with start-of-frame, and after a frame cut short partway through a row.

// File: rtl/hyst_pkg.sv
package hyst_pkg;

    parameter int MAG_W = 8;

    typedef logic [MAG_W-1:0] mag_t;

    typedef struct packed {
        mag_t mag;
        logic inband;
    } px_t;

    // [row][col]; row 0 is the oldest line, col 0 the oldest column
    typedef px_t [2:0][2:0] win_t;

    typedef enum logic [1:0] {
        DEC_SKIP   = 2'd0,
        DEC_STRONG = 2'd1,
        DEC_LINKED = 2'd2,
        DEC_DROP   = 2'd3
    } dec_e;

    function automatic mag_t low_of(mag_t hi);
        return hi >> 1;
    endfunction

    function automatic logic above(mag_t v, mag_t t);
        return v > t;
    endfunction

endpackage

// File: rtl/hyst_line_fifo.sv
module hyst_line_fifo
    import hyst_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] idx,
    input  px_t           din,
    output px_t           dout
);

    px_t mem [DEPTH];

    assign dout = mem[idx];

    always_ff @(posedge clk) begin
        if (en) begin
            mem[idx] <= din;
        end
    end

    assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        en |-> (int'(idx) < DEPTH));

endmodule

// File: rtl/hyst_raster_pos.sv
module hyst_raster_pos #(
    parameter int IMG_W = 16,
    localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          sof,
    output logic [CW-1:0] cur_col,
    output logic [1:0]    cur_row
);

    logic [CW-1:0] nxt_col;
    logic [1:0]    nxt_row;

    always_comb begin
        cur_col = sof ? '0 : nxt_col;
        cur_row = sof ? '0 : nxt_row;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_col <= '0;
            nxt_row <= '0;
        end else if (adv) begin
            if (cur_col == CW'(IMG_W - 1)) begin
                nxt_col <= '0;
                nxt_row <= (cur_row == 2'd2) ? 2'd2 : cur_row + 2'd1;
            end else begin
                nxt_col <= cur_col + 1'b1;
                nxt_row <= cur_row;
            end
        end
    end

    assert_row_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        nxt_row != 2'd3);

    assert_sof_restarts_R9: assert property (@(posedge clk) disable iff (rst)
        (adv && sof && IMG_W > 1) |=> (nxt_col == CW'(1) && nxt_row == 2'd0));

endmodule

// File: rtl/hyst_window.sv
module hyst_window
    import hyst_pkg::*;
(
    input  logic clk,
    input  logic adv,
    input  px_t  tap_top,
    input  px_t  tap_mid,
    input  px_t  tap_bot,
    output win_t win
);

    px_t col_old [3];
    px_t col_mid [3];
    px_t taps    [3];

    always_comb begin
        taps[0] = tap_top;
        taps[1] = tap_mid;
        taps[2] = tap_bot;
    end

    for (genvar r = 0; r < 3; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (adv) begin
                col_old[r] <= col_mid[r];
                col_mid[r] <= taps[r];
            end
        end
    end

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            win[r][0] = col_old[r];
            win[r][1] = col_mid[r];
            win[r][2] = taps[r];
        end
    end

endmodule

// File: rtl/hyst_classify.sv
module hyst_classify
    import hyst_pkg::*;
(
    input  win_t win,
    input  mag_t hi,
    input  logic border,
    output dec_e dec
);

    mag_t lo;
    px_t  ctr;
    logic nbr_strong;

    always_comb begin
        lo  = low_of(hi);
        ctr = win[1][1];
        nbr_strong = 1'b0;
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                if (!(r == 1 && c == 1) && above(win[r][c].mag, hi)) begin
                    nbr_strong = 1'b1;
                end
            end
        end

        if (border || !ctr.inband) begin
            dec = DEC_SKIP;
        end else if (above(ctr.mag, hi)) begin
            dec = DEC_STRONG;
        end else if (ctr.mag >= lo && nbr_strong) begin
            dec = DEC_LINKED;
        end else begin
            dec = DEC_DROP;
        end

        assert_weak_rejected_R3: assert (!(dec inside {DEC_STRONG, DEC_LINKED}) || !(ctr.mag < lo));
        assert_band_needed_R5: assert (!(dec inside {DEC_STRONG, DEC_LINKED}) || ctr.inband);
        assert_link_needs_strong_R4: assert (dec != DEC_LINKED || nbr_strong);
    end

endmodule

// File: rtl/hyst_edge_thresh.sv
module hyst_edge_thresh
    import hyst_pkg::*;
#(
    parameter int IMG_W   = 16,
    parameter int INIT_HI = 100,
    localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [MAG_W-1:0] in_mag,
    input  logic             in_inband,
    input  logic             thr_load,
    input  logic [MAG_W-1:0] thr_value,
    output logic             out_valid,
    output logic             out_edge
);

    px_t           cur_px;
    px_t           line_q [3];
    logic [CW-1:0] cur_col;
    logic [1:0]    cur_row;
    win_t          win;
    dec_e          dec;
    mag_t          hi_pend;
    mag_t          hi_act;
    logic          has_ctr;
    logic          border;

    assign cur_px    = '{mag: in_mag, inband: in_inband};
    assign line_q[0] = cur_px;

    hyst_raster_pos #(.IMG_W(IMG_W)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .adv     (in_valid),
        .sof     (in_sof),
        .cur_col (cur_col),
        .cur_row (cur_row)
    );

    for (genvar k = 0; k < 2; k++) begin : g_line
        hyst_line_fifo #(.DEPTH(IMG_W)) u_line (
            .clk  (clk),
            .rst  (rst),
            .en   (in_valid),
            .idx  (cur_col),
            .din  (line_q[k]),
            .dout (line_q[k+1])
        );
    end

    hyst_window u_win (
        .clk     (clk),
        .adv     (in_valid),
        .tap_top (line_q[2]),
        .tap_mid (line_q[1]),
        .tap_bot (line_q[0]),
        .win     (win)
    );

    assign has_ctr = (cur_row != 2'd0) && (cur_col != '0);
    assign border  = (cur_row == 2'd1) || (cur_col == CW'(1));

    hyst_classify u_cls (
        .win    (win),
        .hi     (hi_act),
        .border (border),
        .dec    (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_pend <= MAG_W'(INIT_HI);
            hi_act  <= MAG_W'(INIT_HI);
        end else begin
            if (thr_load) begin
                hi_pend <= thr_value;
            end
            if (in_valid && in_sof) begin
                hi_act <= thr_load ? thr_value : hi_pend;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_edge  <= 1'b0;
        end else begin
            out_valid <= in_valid && has_ctr;
            out_edge  <= in_valid && has_ctr && (dec inside {DEC_STRONG, DEC_LINKED});
        end
    end

    assert_edge_implies_valid_R1: assert property (@(posedge clk) disable iff (rst)
        out_edge |-> out_valid);

    assert_out_follows_input_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_thr_frame_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_sof) |=> $stable(hi_act));

    assert_border_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_row == 2'd1) |=> !out_edge);

endmodule

// File: tb/hyst_edge_thresh_tb.sv
module hyst_edge_thresh_tb;

    localparam int W    = 8;
    localparam int MAXR = 8;
    localparam int IHI  = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_mag = '0;
    logic       in_inband = 1'b0;
    logic       thr_load = 1'b0;
    logic [7:0] thr_value = '0;
    logic       out_valid;
    logic       out_edge;

    int checks = 0;
    int errors = 0;

    int img [MAXR][W];
    bit flg [MAXR][W];
    int br = 0, bc = 0;
    int act_hi = IHI, pend_hi = IHI;

    always #2 clk = ~clk;

    hyst_edge_thresh #(.IMG_W(W), .INIT_HI(IHI)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_mag(in_mag), .in_inband(in_inband), .thr_load(thr_load),
        .thr_value(thr_value), .out_valid(out_valid), .out_edge(out_edge)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic bit ref_edge(input int r, input int c, output string cat);
        int lo;
        bit nb;
        lo = act_hi >> 1;
        if (r == 0 || c == 0) begin cat = "R6"; return 0; end
        if (!flg[r][c]) begin cat = "R5"; return 0; end
        if (img[r][c] > act_hi) begin cat = "R2"; return 1; end
        if (img[r][c] < lo) begin cat = "R3"; return 0; end
        cat = "R4";
        nb = 0;
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                if (!(dr == 0 && dc == 0) && img[r+dr][c+dc] > act_hi) nb = 1;
        return nb;
    endfunction

    task automatic send(input bit v, input bit s, input int m, input bit f,
                        input bit ld, input int lv, input string tag);
        bit    ev, ee;
        string cat;
        in_valid = v; in_sof = s; in_mag = 8'(m); in_inband = f;
        thr_load = ld; thr_value = 8'(lv);
        @(posedge clk);
        ev = 0; ee = 0; cat = "R8";
        if (v) begin
            if (s) begin
                br = 0; bc = 0;
                act_hi = ld ? lv : pend_hi;
            end
            img[br][bc] = m;
            flg[br][bc] = f;
            cat = "R1";
            if (br >= 1 && bc >= 1) begin
                ev = 1;
                ee = ref_edge(br - 1, bc - 1, cat);
            end
            if (bc == W - 1) begin bc = 0; br++; end else bc++;
        end
        if (ld) pend_hi = lv;
        @(negedge clk);
        thr_load = 0;
        if (tag != "") cat = tag;
        check(v ? "R1" : "R8", "out_valid", int'(out_valid), int'(ev));
        check(cat, "out_edge", int'(out_edge), int'(ee));
    endtask

    function automatic int dir_mag(input int r, input int c);
        case ({r[7:0], c[7:0]})
            {8'd0, 8'd3}: return 200;
            {8'd2, 8'd0}: return 200;
            {8'd2, 8'd2}: return 150;
            {8'd2, 8'd3}: return 70;
            {8'd3, 8'd3}: return 50;
            {8'd3, 8'd2}: return 49;
            {8'd1, 8'd5}: return 100;
            {8'd3, 8'd6}: return 70;
            {8'd2, 8'd4}: return 200;
            default:      return 0;
        endcase
    endfunction

    function automatic int pick_mag();
        int lo, k;
        lo = act_hi >> 1;
        k = $urandom_range(0, 7);
        case (k)
            0: return act_hi + 1;
            1: return act_hi;
            2: return lo;
            3: return (lo > 0) ? lo - 1 : 0;
            4: return (act_hi + lo) / 2;
            5: return (act_hi < 255) ? $urandom_range(act_hi + 1, 255) : 255;
            default: return $urandom_range(0, 255);
        endcase
    endfunction

    task automatic frame(input int rows, input bit gaps, input string tag);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < W; c++) begin
                if (gaps && $urandom_range(0, 3) == 0) send(0, 0, 0, 0, 0, 0, "");
                send(1, (r == 0 && c == 0), pick_mag(), $urandom_range(0, 5) != 0, 0, 0, tag);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", "reset out_valid", int'(out_valid), 0);
        check("R1", "reset out_edge", int'(out_edge), 0);
        rst = 0;

        // directed frame at the reset threshold: exact bounds, links, band, border
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < W; c++)
                send(1, (r == 0 && c == 0), dir_mag(r, c), !(r == 2 && c == 4), 0, 0, "");

        // same frame with stalls between pixels
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < W; c++) begin
                send(0, 0, 0, 0, 0, 0, "");
                send(1, (r == 0 && c == 0), dir_mag(r, c), 1, 0, 0, "");
            end

        // mid-frame load must not affect the running frame
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < W; c++)
                send(1, (r == 0 && c == 0), (c == 3) ? 60 : 30, 1,
                     (r == 1 && c == 2), 25, "R7");
        frame(4, 0, "R7");
        // load together with start-of-frame
        send(1, 1, 40, 1, 1, 180, "R7");
        for (int k = 1; k < 3 * W; k++) send(1, 0, (k % 5 == 0) ? 185 : 120, 1, 0, 0, "R7");

        // frame cut short partway through a row, then a fresh frame
        for (int k = 0; k < 2 * W + 3; k++) send(1, (k == 0), pick_mag(), 1, 0, 0, "");
        frame(4, 0, "R9");

        // random frames with random thresholds and gaps
        for (int n = 0; n < 30; n++) begin
            if ($urandom_range(0, 1) == 1) send(0, 0, 0, 0, 1, $urandom_range(10, 220), "");
            frame($urandom_range(3, MAXR), $urandom_range(0, 1), "");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule